// File: doc/BRIEF.md
# Low-Power State Controller for a Small Microcontroller Core

This block decides when the processor clock and the peripheral clock of a small microcontroller run, and how the core leaves each low-power state. Software requests a state through a two-bit mode register. The request is acted on only at the end of the current machine cycle. A machine cycle is a fixed number of oscillator periods.

In the light sleep state, only the processor clock stops. Timers, the serial port and interrupt logic keep running. Any enabled interrupt line wakes the core at once. If the hardware reset pin wakes the core instead, the processor runs on for a fixed window of two machine cycles before the internal reset takes over. During that window, writes to internal RAM are blocked.

In the deep sleep state, every oscillator-derived clock stops and interrupts are ignored. Only the hardware reset pin ends it. The internal reset is then held with the clocks still off for a fixed stabilisation count. After that the clocks return while reset is still held. Reset clears the mode bits and never touches RAM contents. A separate power-on reset initialises the controller's own flip-flops.

Top module: `lowpwr_ctrl`

## Requirements
- R1: With mode bit 0 (light sleep) taking effect, `cpu_clk_en` is 0 while `per_clk_en` stays 1 and `int_rst` stays 0, and the state holds while no interrupt or reset arrives.
- R2: In light sleep, a high level on any single line of `irq_req` sets `cpu_clk_en` to 1 and clears `mode_rd` to 0 at the next clock edge.
- R3: With mode bit 1 (deep sleep) taking effect, `cpu_clk_en` and `per_clk_en` are both 0. Holding all `irq_req` lines high leaves both enables at 0 and `mode_rd` unchanged.
- R4: `hw_rst_n` passes through a two-stage synchroniser. From running, a low pin sets `int_rst` on the third clock edge and clears `mode_rd`. `int_rst` stays at 1 while the pin is low and falls on the third edge after the pin rises. `mode_rd` is 0 whenever `int_rst` is 1, and `ram_wr_inhibit` is 1 whenever `int_rst` is 1.
- R5: When the reset pin ends light sleep, `cpu_clk_en` is 1, `ram_wr_inhibit` is 1 and `int_rst` is 0 for exactly RST_LAG_MC×MC_LEN cycles. After that, `int_rst` rises.
- R6: When the reset pin ends deep sleep, `int_rst` is 1 and `per_clk_en` is 0 for exactly STAB_CYC cycles. After that, both clock enables are 1 with `int_rst` still 1 until the pin is released.
- R7: A write to the mode register during cycle j of a machine cycle (0 ≤ j < MC_LEN) takes effect at the edge that closes cycle MC_LEN-1. `cpu_clk_en` therefore stays 1 for MC_LEN-j cycles, counting the write cycle.
- R8: Writing both bits set (value 3) selects deep sleep. Writing 0 enters no low-power state. `mode_wdata` bit 0 requests light sleep and bit 1 requests deep sleep.
- R9: Writes to the mode register are accepted only while running. In either sleep state, a write leaves `mode_rd` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset of the controller, active low, asynchronous |
| hw_rst_n | input | 1 | External hardware reset pin, active low, synchronised inside |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode write data: bit 0 light sleep, bit 1 deep sleep |
| irq_req | input | N_IRQ | Enabled interrupt request lines |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| int_rst | output | 1 | Internal reset, active high |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| mode_rd | output | 2 | Current mode register value |

## Verification
The bench sweeps every write offset within a machine cycle against each of the three non-zero mode codes. The offset sweep shows whether entry is aligned to the machine-cycle boundary or follows the write directly. The code sweep shows light sleep, deep sleep and the priority of deep sleep when both bits are set. Each light-sleep entry is left either by a different interrupt line or by the reset pin. Each deep-sleep entry is first flooded with interrupts and then left by the reset pin. This separates the interrupt-wake path, the RAM-inhibit window length and the stabilisation length, and shows that a write of zero enters no sleep state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    S_RESET  = 3'd0,
    S_RUN    = 3'd1,
    S_IDLE   = 3'd2,
    S_PDOWN  = 3'd3,
    S_RSTWIN = 3'd4,
    S_STAB   = 3'd5
  } lpm_state_e;

  localparam int MODE_W  = 2;
  localparam int BIT_IDL = 0;
  localparam int BIT_PD  = 1;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic rst_s
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  assign sh_d[0] = ~pin_n;

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      assign sh_d[gi] = sh_q[gi-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_s = sh_q[STAGES-1];
endmodule

// File: rtl/lpm_mcycle.sv
module lpm_mcycle #(
  parameter int MC_LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic mc_last
);
  localparam int W = (MC_LEN > 1) ? $clog2(MC_LEN) : 1;
  localparam logic [W-1:0] LAST = W'(MC_LEN - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign mc_last = (cnt_q == LAST);
endmodule

// File: rtl/lpm_dtimer.sv
module lpm_dtimer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         done
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = load_val;
    else if (dec && cnt_q != '0)  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int RST_LAG  = 24,
  parameter int STAB_CYC = 100,
  parameter int TW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_s,
  input  logic              irq_any,
  input  logic              mc_last,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  input  logic              tmr_done,
  output lpm_state_e        st_q,
  output logic [MODE_W-1:0] ctrl_q,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              tmr_dec,
  output logic              mc_clr,
  output logic              mc_adv
);
  lpm_state_e        st_d;
  logic [MODE_W-1:0] ctrl_d;

  always_comb begin
    st_d     = st_q;
    ctrl_d   = ctrl_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      S_RESET: begin
        ctrl_d = '0;
        if (!rst_s) st_d = S_RUN;
      end
      S_RUN: begin
        if (wr) ctrl_d = wdata;
        if (rst_s) begin
          st_d   = S_RESET;
          ctrl_d = '0;
        end else if (mc_last) begin
          if (ctrl_d[BIT_PD])       st_d = S_PDOWN;
          else if (ctrl_d[BIT_IDL]) st_d = S_IDLE;
        end
      end
      S_IDLE: begin
        if (rst_s) begin
          st_d     = S_RSTWIN;
          tmr_load = 1'b1;
          tmr_val  = TW'(RST_LAG - 1);
        end else if (irq_any) begin
          st_d   = S_RUN;
          ctrl_d = '0;
        end
      end
      S_PDOWN: begin
        if (rst_s) begin
          st_d     = S_STAB;
          ctrl_d   = '0;
          tmr_load = 1'b1;
          tmr_val  = TW'(STAB_CYC - 1);
        end
      end
      S_RSTWIN: begin
        if (tmr_done) begin
          st_d   = S_RESET;
          ctrl_d = '0;
        end
      end
      S_STAB: begin
        if (tmr_done) st_d = S_RESET;
      end
      default: begin
        st_d   = S_RESET;
        ctrl_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_RESET;
      ctrl_q <= '0;
    end else begin
      st_q   <= st_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign tmr_dec = (st_q == S_RSTWIN) || (st_q == S_STAB);
  assign mc_clr  = (st_q == S_RESET) || (st_q == S_STAB) || (st_q == S_PDOWN);
  assign mc_adv  = !mc_clr;
endmodule

// File: rtl/lowpwr_ctrl.sv
module lowpwr_ctrl
  import lpm_pkg::*;
#(
  parameter int MC_LEN      = 12,
  parameter int RST_LAG_MC  = 2,
  parameter int STAB_CYC    = 100,
  parameter int N_IRQ       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_osc,
  input  logic             por_n,
  input  logic             hw_rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic [N_IRQ-1:0] irq_req,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             int_rst,
  output logic             ram_wr_inhibit,
  output logic [1:0]       mode_rd
);
  localparam int RST_LAG = RST_LAG_MC * MC_LEN;
  localparam int MAXC    = (RST_LAG > STAB_CYC) ? RST_LAG : STAB_CYC;
  localparam int TW      = $clog2(MAXC + 1);

  logic          rst_sync;
  logic          mc_last;
  logic          mc_clr;
  logic          mc_adv;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_dec;
  logic          tmr_done;
  lpm_state_e    st;

  lpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_osc),
    .rst_n (por_n),
    .pin_n (hw_rst_n),
    .rst_s (rst_sync)
  );

  lpm_mcycle #(.MC_LEN(MC_LEN)) u_mc (
    .clk     (clk_osc),
    .rst_n   (por_n),
    .clr     (mc_clr),
    .adv     (mc_adv),
    .mc_last (mc_last)
  );

  lpm_dtimer #(.W(TW)) u_tmr (
    .clk      (clk_osc),
    .rst_n    (por_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .done     (tmr_done)
  );

  lpm_fsm #(.RST_LAG(RST_LAG), .STAB_CYC(STAB_CYC), .TW(TW)) u_fsm (
    .clk      (clk_osc),
    .rst_n    (por_n),
    .rst_s    (rst_sync),
    .irq_any  (|irq_req),
    .mc_last  (mc_last),
    .wr       (mode_wr),
    .wdata    (mode_wdata),
    .tmr_done (tmr_done),
    .st_q     (st),
    .ctrl_q   (mode_rd),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .tmr_dec  (tmr_dec),
    .mc_clr   (mc_clr),
    .mc_adv   (mc_adv)
  );

  assign cpu_clk_en     = (st == S_RESET) || (st == S_RUN) || (st == S_RSTWIN);
  assign per_clk_en     = cpu_clk_en || (st == S_IDLE);
  assign int_rst        = (st == S_RESET) || (st == S_STAB);
  assign ram_wr_inhibit = int_rst || (st == S_RSTWIN);
endmodule

// File: rtl/lpm_chk.sv
module lpm_chk #(
  parameter int N_IRQ = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             int_rst,
  input logic             ram_wr_inhibit,
  input logic [1:0]       mode_rd,
  input logic [N_IRQ-1:0] irq_req,
  input logic             rst_s,
  input logic             mc_last
);
  p_irq_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && !rst_s && (|irq_req)) |=> (cpu_clk_en && mode_rd == 2'b00));

  p_pd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_clk_en && !int_rst && !rst_s) |=> (!per_clk_en && !int_rst));

  p_rst_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> (mode_rd == 2'b00 && ram_wr_inhibit));

  p_win_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ram_wr_inhibit) && !int_rst) |-> $past(!cpu_clk_en && per_clk_en));

  p_entry_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_clk_en) && !int_rst) |-> $past(mc_last));

  p_pd_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_clk_en) && !int_rst && mode_rd[1]) |-> !per_clk_en);
endmodule

bind lowpwr_ctrl lpm_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk            (clk_osc),
  .rst_n          (por_n),
  .cpu_clk_en     (cpu_clk_en),
  .per_clk_en     (per_clk_en),
  .int_rst        (int_rst),
  .ram_wr_inhibit (ram_wr_inhibit),
  .mode_rd        (mode_rd),
  .irq_req        (irq_req),
  .rst_s          (rst_sync),
  .mc_last        (mc_last)
);

// File: tb/sim_lowpwr_ctrl.sv
module sim_lowpwr_ctrl;
  localparam int MC   = 12;
  localparam int LAGM = 2;
  localparam int STAB = 100;
  localparam int NIRQ = 5;
  localparam int SYNC = 2;
  localparam int WIN  = LAGM * MC;
  localparam int HOLD = STAB + WIN + 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            por_n, hw_rst_n, mode_wr;
  logic [1:0]      mode_wdata;
  logic [NIRQ-1:0] irq_req;
  logic            cpu_clk_en, per_clk_en, int_rst, ram_wr_inhibit;
  logic [1:0]      mode_rd;

  int n_chk = 0;
  int n_bad = 0;

  lowpwr_ctrl #(.MC_LEN(MC), .RST_LAG_MC(LAGM), .STAB_CYC(STAB),
                .N_IRQ(NIRQ), .SYNC_STAGES(SYNC)) u0 (
    .clk_osc(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .irq_req(irq_req), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .int_rst(int_rst), .ram_wr_inhibit(ram_wr_inhibit),
    .mode_rd(mode_rd));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // prev: 0 running, 1 light sleep, 2 deep sleep
  task automatic do_reset(input int prev);
    int stab_n = 0;
    int win_n  = 0;
    int bad_md = 0;
    int w      = 0;
    hw_rst_n = 1'b0;
    for (int c = 0; c < HOLD; c++) begin
      @(negedge clk);
      if (prev == 0 && c == SYNC) check(int_rst == 1'b1, "R4 assert latency", int_rst, 1);
      if (int_rst && !per_clk_en) stab_n++;
      if (cpu_clk_en && ram_wr_inhibit && !int_rst) win_n++;
      if (int_rst && (mode_rd != 2'b00 || !ram_wr_inhibit)) bad_md++;
    end
    check(bad_md == 0, "R4 mode cleared in reset", bad_md, 0);
    check(int_rst && cpu_clk_en && per_clk_en, "R6 held reset clocks on",
          {int_rst, cpu_clk_en, per_clk_en}, 7);
    check(win_n == ((prev == 1) ? WIN : 0), "R5 window length", win_n, (prev == 1) ? WIN : 0);
    check(stab_n == ((prev == 2) ? STAB : 0), "R6 stabilisation length", stab_n,
          (prev == 2) ? STAB : 0);
    hw_rst_n = 1'b1;
    while (int_rst && w < 10) begin
      @(negedge clk);
      w++;
    end
    check(w == SYNC + 1, "R4 release latency", w, SYNC + 1);
  endtask

  initial begin
    int prev = 0;
    int n;
    int offc;
    por_n = 1'b0; hw_rst_n = 1'b1; mode_wr = 1'b0; mode_wdata = 2'b00; irq_req = '0;
    repeat (3) @(negedge clk);
    check(int_rst && cpu_clk_en && per_clk_en && ram_wr_inhibit && mode_rd == 2'b00,
          "R4 power-on state", {int_rst, cpu_clk_en, per_clk_en, ram_wr_inhibit}, 15);
    por_n = 1'b1;
    @(negedge clk);
    check(!int_rst && !ram_wr_inhibit, "R4 running after power-on", int_rst, 0);

    for (int code = 1; code <= 3; code++) begin
      for (int j = 0; j < MC; j++) begin
        do_reset(prev);
        repeat (j) @(negedge clk);
        mode_wr = 1'b1; mode_wdata = 2'(code); n = 0;
        while (cpu_clk_en && n < 40) begin
          n++;
          @(negedge clk);
          mode_wr = 1'b0;
        end
        check(n == MC - j, "R7 entry at machine-cycle end", n, MC - j);
        check(per_clk_en == (code == 1), (code == 1) ? "R1 light sleep clocks" : "R8 deep sleep priority",
              per_clk_en, (code == 1) ? 1 : 0);
        check(mode_rd == 2'(code) && !int_rst, "R1 mode held in sleep", mode_rd, code);
        mode_wr = 1'b1; mode_wdata = 2'b00;
        @(negedge clk);
        mode_wr = 1'b0;
        check(mode_rd == 2'(code), "R9 write ignored in sleep", mode_rd, code);
        if (code == 1) begin
          repeat (5) @(negedge clk);
          check(!cpu_clk_en && per_clk_en && !int_rst, "R1 light sleep holds",
                {cpu_clk_en, per_clk_en}, 1);
          if (j % 2 == 0) begin
            irq_req = NIRQ'(1) << (j % NIRQ);
            @(negedge clk);
            irq_req = '0;
            check(cpu_clk_en && mode_rd == 2'b00, "R2 interrupt wake", {cpu_clk_en, mode_rd}, 4);
            prev = 0;
          end else begin
            prev = 1;
          end
        end else begin
          irq_req = '1;
          repeat (30) @(negedge clk);
          check(!cpu_clk_en && !per_clk_en && mode_rd == 2'(code), "R3 interrupts ignored",
                {cpu_clk_en, per_clk_en, mode_rd}, code);
          irq_req = '0;
          prev = 2;
        end
      end
    end

    do_reset(prev);
    mode_wr = 1'b1; mode_wdata = 2'b00;
    @(negedge clk);
    mode_wr = 1'b0;
    offc = 0;
    for (int c = 0; c < 3 * MC; c++) begin
      @(negedge clk);
      if (!cpu_clk_en) offc++;
    end
    check(offc == 0, "R8 zero write enters no sleep", offc, 0);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end
endmodule